// File: doc/BRIEF.md
# Two-Wire Remote 8-Bit Port Expander

This block is a target on a two-wire serial bus. It gives a controller one 8-bit quasi-bidirectional port and an active-low change interrupt. A system clock oversamples the bus clock and data lines. The block drives the data line only by pulling it low, through an enable.

The 7-bit target address has two parts. The upper four bits are fixed and the lower three come from strap inputs.

A write transfer works as follows. Every data byte that follows the address goes into the port latch. A zero bit in the latch pulls its pin low, and a one bit leaves the pin free to act as an input.

A read transfer works as follows. The block samples the live pin levels and shifts them out. It keeps sampling and sending new bytes for as long as the controller acknowledges.

The interrupt goes low when the pins differ from the value captured at the last read or write.

Top module: `port_expander_i2c`

## Requirements
- R1: The block responds only to an address byte whose bits 7..4 are 4'b0100, whose bits 3..1 equal `strapAddr`, and whose bit 0 is the direction (1 = read, 0 = write). Bits arrive MSB first. After any other address byte, the block drives no acknowledge and ignores all data bytes until the next START.
- R2: The block acknowledges a matching address byte and every write data byte by holding `sdaOe` high for the ninth clock of that byte.
- R3: After reset, `portOut` is 8'hFF, `sdaOe` is 0 and `intN` is 1.
- R4: Each write data byte is applied to `portOut` when SCL falls at the end of that byte's acknowledge clock. Any number of bytes may follow one address, and each byte updates the port.
- R5: A read returns the synchronized pin levels, MSB first. The pins are sampled at the falling SCL edge that ends the address acknowledge, and again at the falling edge that ends each controller ACK. A pin the block itself drives low reads as 0. A pin change after a sample is not seen until the next sample.
- R6: When the controller NACKs a read byte, the block releases SDA and drives nothing more until the next START.
- R7: A STOP (SDA rising while SCL is high) ends the transfer at any point. A partially received byte is discarded, and `portOut` keeps the last value it was given.
- R8: `intN` goes low within 4 clock cycles after the pin levels come to differ from the last captured value. A read address acknowledge clears it. A write to the port with the pins unchanged also clears it.
- R9: A START (SDA falling while SCL is high) restarts the address phase from any state, including in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapAddr | input | 3 | Low three address bits |
| pinIn | input | 8 | Actual level of each port pin |
| sdaOe | output | 1 | When high, pull the data line low |
| portOut | output | 8 | Port latch; a 0 bit pulls its pin low |
| intN | output | 1 | Active-low pin-change interrupt |

## Verification
If the bit counter or state is wrong, the acknowledge slot is missed or shifted. The controller sees this at the ninth clock of the same byte, either as a missing ACK or as a misaligned read byte. If the receive shift register is corrupted, `portOut` shows the wrong value at the end of that byte's acknowledge. If the reference capture is wrong, `intN` stays low after a read or write that should clear it, and this is visible a few cycles after the acknowledge. The bench sweeps every write value and a spread of pin patterns, so a single wrong bit position shows up in the first affected byte.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRITE, ST_WRITE_ACK, ST_READ, ST_READ_ACK
  } busState_t;

  typedef struct packed {
    logic rxShift;     // shift the sampled SDA bit into the receive register
    logic rxBit;       // sampled SDA value
    logic txLoad;      // capture pins into transmit register and reference
    logic txShift;     // advance transmit register by one bit
    logic latchWrite;  // move received byte to the port latch
  } strobe_t;
endpackage

// File: rtl/pxp_ctrl.sv
module pxp_ctrl
  import pxp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b0100,
  parameter int STRAP_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [DATA_W-1:0]  rxByte,
  input  logic               txMsb,
  output strobe_t            stb,
  output logic               sdaOe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclD, sdaD, sclS, sdaS;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic isRead, ackSeen, addrMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign addrMatch = (rxByte[DATA_W-1:1] == {ADDR_HI, strapAddr});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      ackSeen <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == FULL) begin
            if (addrMatch) begin
              isRead <= rxByte[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= isRead ? ST_READ : ST_WRITE;
        end
        ST_WRITE: begin
          if (sclRise && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == FULL) state <= ST_WRITE_ACK;
        end
        ST_WRITE_ACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= ST_WRITE;
        end
        ST_READ: begin
          if (sclRise && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == FULL) state <= ST_READ_ACK;
        end
        ST_READ_ACK: begin
          if (sclRise) ackSeen <= ~sdaS;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= ackSeen ? ST_READ : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    stb.rxBit = sdaS;
    if (sclRise && (state == ST_ADDR || state == ST_WRITE) && bitCnt < FULL)
      stb.rxShift = 1'b1;
    if (sclFall && ((state == ST_ADDR_ACK && isRead) || (state == ST_READ_ACK && ackSeen)))
      stb.txLoad = 1'b1;
    if (sclFall && state == ST_READ && bitCnt != FULL)
      stb.txShift = 1'b1;
    if (sclFall && state == ST_WRITE_ACK)
      stb.latchWrite = 1'b1;
  end

  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_WRITE_ACK: sdaOe = 1'b1;
      ST_READ:                   sdaOe = ~txMsb;
      default:                   sdaOe = 1'b0;
    endcase
  end

  // R6: an idle target never touches the data line
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !sdaOe);
  // R9: a START always reopens the address phase with a cleared counter
  p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == '0));
  // R7: a STOP always returns to idle
  p_stop_idles_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> state == ST_IDLE);
  // R2: the bit counter never passes one byte
  p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL);
  // R4: datapath strobes never collide
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rxShift, stb.txLoad, stb.txShift, stb.latchWrite}));
endmodule

// File: rtl/pxp_data.sv
module pxp_data
  import pxp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] rxByte,
  output logic              txMsb,
  output logic [DATA_W-1:0] portOut,
  output logic              intN
);
  logic [DATA_W-1:0] pinStage [SYNC_STAGES];
  logic [DATA_W-1:0] pinSync, txReg, refVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) pinStage[i] <= '1;
    end else begin
      pinStage[0] <= pinIn;
      for (int i = 1; i < SYNC_STAGES; i++) pinStage[i] <= pinStage[i-1];
    end
  end
  assign pinSync = pinStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txReg   <= '1;
      portOut <= '1;
      refVal  <= '1;
      intN    <= 1'b1;
    end else begin
      if (stb.rxShift) rxByte <= {rxByte[DATA_W-2:0], stb.rxBit};
      if (stb.txLoad) begin
        txReg  <= pinSync;
        refVal <= pinSync;
      end else if (stb.txShift) begin
        txReg <= {txReg[DATA_W-2:0], 1'b1};
      end
      if (stb.latchWrite) begin
        portOut <= rxByte;
        refVal  <= pinSync;
      end
      intN <= (pinSync == refVal);
    end
  end
  assign txMsb = txReg[DATA_W-1];

  // R4: the port changes only right after a write strobe from control
  p_latch_on_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portOut) |-> $past(stb.latchWrite));
  // R8: a capture with quiet pins leaves the interrupt released
  p_int_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.txLoad) && $stable(pinSync)) |=> intN);
endmodule

// File: rtl/port_expander_i2c.sv
module port_expander_i2c
  import pxp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STRAP_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [DATA_W-1:0]  pinIn,
  output logic               sdaOe,
  output logic [DATA_W-1:0]  portOut,
  output logic               intN
);
  strobe_t stb;
  logic [DATA_W-1:0] rxByte;
  logic txMsb;

  pxp_ctrl #(.DATA_W(DATA_W), .STRAP_W(STRAP_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapAddr(strapAddr),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe));

  pxp_data #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .pinIn(pinIn), .rxByte(rxByte),
    .txMsb(txMsb), .portOut(portOut), .intN(intN));
endmodule

// File: tb/sim_port_expander_i2c.sv
module sim_port_expander_i2c;
  localparam int Q = 5;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, sclIn, mSda;
  logic [7:0] ext;
  logic [2:0] strap;
  wire sdaOe, intN;
  wire [7:0] portOut;
  wire sdaBus = mSda & ~sdaOe;
  wire [7:0] pinIn = portOut & ext;
  int nChk = 0, nFail = 0;

  port_expander_i2c u0 (.clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaBus),
    .strapAddr(strap), .pinIn(pinIn), .sdaOe(sdaOe), .portOut(portOut), .intN(intN));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask
  task automatic busStart();
    mSda = 1'b1; wq(Q); sclIn = 1'b1; wq(Q); mSda = 1'b0; wq(Q); sclIn = 1'b0; wq(Q);
  endtask
  task automatic busStop();
    mSda = 1'b0; wq(Q); sclIn = 1'b1; wq(Q); mSda = 1'b1; wq(Q);
  endtask
  task automatic sendBit(input logic b);
    mSda = b; wq(Q); sclIn = 1'b1; wq(2 * Q); sclIn = 1'b0; wq(Q);
  endtask
  task automatic sendByte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mSda = 1'b1; wq(Q); sclIn = 1'b1; wq(Q); ackd = !sdaBus; wq(Q); sclIn = 1'b0; wq(Q);
  endtask
  task automatic readByte(input logic ack, output logic [7:0] v);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); sclIn = 1'b1; wq(Q); v[i] = sdaBus; wq(Q); sclIn = 1'b0;
    end
    mSda = !ack; wq(Q); sclIn = 1'b1; wq(2 * Q); sclIn = 1'b0; wq(Q); mSda = 1'b1;
  endtask

  function automatic logic [7:0] addrByte(input logic [2:0] s, input logic rd);
    return {4'b0100, s, rd};
  endfunction

  task automatic writeOne(input logic [7:0] v);
    logic a;
    busStart(); sendByte(addrByte(strap, 1'b0), a); sendByte(v, a); busStop();
  endtask

  task automatic readOne(output logic [7:0] v);
    logic a;
    busStart(); sendByte(addrByte(strap, 1'b1), a); readByte(1'b0, v); busStop();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v, w;
    rstN = 1'b0; sclIn = 1'b1; mSda = 1'b1; ext = 8'hFF; strap = 3'b101;
    wq(5); rstN = 1'b1; wq(3);
    chk("R3 portOut", portOut, 8'hFF);
    chk("R3 sdaOe", sdaOe, 1'b0);
    chk("R3 intN", intN, 1'b1);

    // write sweep: every value in one transfer
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    chk("R1 R2 write address ack", a, 1'b1);
    for (int k = 0; k < 256; k++) begin
      sendByte(k[7:0], a);
      chk("R2 data ack", a, 1'b1);
      chk("R4 port value", portOut, k[7:0]);
    end
    sendByte(8'hFF, a);
    busStop();
    chk("R4 port restored", portOut, 8'hFF);

    // wrong address: no ack, data ignored
    busStart();
    sendByte(addrByte(strap ^ 3'b001, 1'b0), a);
    chk("R1 mismatch no ack", a, 1'b0);
    sendByte(8'h00, a);
    chk("R1 data no ack", a, 1'b0);
    chk("R1 port untouched", portOut, 8'hFF);
    busStop();
    busStart();
    sendByte({4'b0110, strap, 1'b0}, a);
    chk("R1 upper bits mismatch", a, 1'b0);
    busStop();

    // read sweep of pin patterns
    for (int k = 0; k < 32; k++) begin
      ext = 8'(k * 37 + 5); wq(4);
      busStart();
      sendByte(addrByte(strap, 1'b1), a);
      chk("R1 read address ack", a, 1'b1);
      readByte(1'b0, v);
      chk("R5 read pins", v, ext);
      // R6: after NACK one more clock pulse shows a released line
      wq(Q); sclIn = 1'b1; wq(Q);
      chk("R6 released after nack", sdaBus, 1'b1);
      wq(Q); sclIn = 1'b0; wq(Q);
      busStop();
      chk("R8 intN after read", intN, 1'b1);
    end

    // output-driven pins read their actual level
    ext = 8'hFF;
    writeOne(8'h0F); wq(4);
    readOne(v);
    chk("R5 driven pins read low", v, 8'h0F);

    // sample once per byte, repeated while acknowledged
    writeOne(8'hFF); ext = 8'hA5; wq(4);
    busStart();
    sendByte(addrByte(strap, 1'b1), a);
    readByte(1'b1, v);
    chk("R5 first byte", v, 8'hA5);
    ext = 8'h3C;
    readByte(1'b1, v);
    chk("R5 change after sample not seen", v, 8'hA5);
    readByte(1'b0, v);
    chk("R5 next sample sees change", v, 8'h3C);
    busStop();

    // STOP mid-byte keeps the previous latch
    ext = 8'hFF;
    writeOne(8'h5A);
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    wq(4);
    chk("R7 partial byte dropped", portOut, 8'h5A);
    chk("R7 released after stop", sdaOe, 1'b0);

    // repeated START mid-byte
    busStart();
    sendByte(addrByte(strap, 1'b0), a);
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    busStart();
    sendByte(addrByte(strap, 1'b1), a);
    chk("R9 restart address ack", a, 1'b1);
    readByte(1'b0, v);
    busStop();
    chk("R9 restart read", v, 8'h5A);
    chk("R9 port kept", portOut, 8'h5A);

    // interrupt set and clear
    writeOne(8'hFF); wq(4);
    readOne(v); wq(4);
    chk("R8 idle released", intN, 1'b1);
    ext = 8'h77; wq(4);
    chk("R8 asserted on change", intN, 1'b0);
    busStart();
    sendByte(addrByte(strap, 1'b1), a);
    chk("R8 cleared by read address ack", intN, 1'b1);
    readByte(1'b0, w);
    busStop();
    chk("R5 read value", w, 8'h77);
    ext = 8'h11; wq(4);
    chk("R8 asserted again", intN, 1'b0);
    writeOne(8'hFF); wq(2);
    chk("R8 cleared by write", intN, 1'b1);

    summary();
    $finish;
  end
endmodule